// File: doc/BRIEF.md
# Byte-Merging Quadword Input Queue

This block sits at the entry of a command stream whose natural unit is a 16-byte quadword, while the bus in front of it may deliver that quadword in pieces. Each write names a starting byte lane inside the quadword, a byte count and a data word whose low bytes hold the payload. Written bytes are merged lane by lane into a holding register, and a 16-bit lane mask records which lanes have been filled since the last commit.

When the final missing lane arrives, in whatever order the pieces came, the mask is cleared and the assembled quadword is committed, together with the 32-bit source tag carried by the completing write, into a small staging slot. The slot feeds a quadword FIFO whose head is offered downstream as a valid/ready stream with an occupancy count. If the FIFO is full and the slot is still occupied, the write port drops its ready signal, so no completed quadword is ever lost. A flush input discards a partly assembled quadword without touching anything already committed.

Top module: `qword_gather_fifo`

## Requirements
- R1: After reset, `rd_valid_o` is 0, `level_o` is 0 and `wr_ready_o` is 1.
- R2: An accepted write that leaves any of the 16 lanes unfilled pushes nothing: `level_o` does not rise.
- R3: Byte k of `wr_data_i` (bits 8k+7..8k) lands in lane `wr_off_i`+k for k below `wr_cnt_i`; lane L of a committed quadword appears at bits 8L+7..8L of `rd_data_o`. Bytes that would fall past lane 15 are discarded, and a count of 0 changes nothing.
- R4: When every lane has been filled, in any order, exactly one entry is pushed and the lane mask starts empty again.
- R5: Writing a lane that is already filled replaces its byte and does not by itself complete the quadword.
- R6: The tag delivered on `rd_tag_o` with an entry is the `wr_tag_i` of the write that completed it.
- R7: Entries leave in commit order; `level_o` counts stored entries (at most DEPTH), `rd_valid_o` is high exactly when it is nonzero, and the head is held stable while `rd_ready_i` is low.
- R8: With the FIFO full and a completed quadword waiting in the staging slot, `wr_ready_o` is 0; the waiting quadword enters the FIFO once an entry is read.
- R9: `flush_i` empties the lane mask, so lanes filled before it must be written again; committed entries are unaffected.
- R10: A completing write accepted at clock edge N shows up in `level_o` after edge N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard the partly assembled quadword |
| wr_valid_i | input | 1 | Write request |
| wr_ready_o | output | 1 | Write accepted on this edge when high |
| wr_off_i | input | 4 | First byte lane of the write |
| wr_cnt_i | input | 5 | Number of bytes, 0 to 16 |
| wr_data_i | input | 128 | Payload, byte 0 in the low bits |
| wr_tag_i | input | 32 | Source tag recorded if this write completes a quadword |
| rd_valid_o | output | 1 | FIFO head is valid |
| rd_ready_i | input | 1 | Consumer takes the head |
| rd_data_o | output | 128 | Head quadword |
| rd_tag_o | output | 32 | Head source tag |
| level_o | output | 3 | Number of stored entries (width follows DEPTH) |

## Verification
The hardest state to reach from the ports is the one where the FIFO is full and a further completed quadword is parked in the staging slot, since that needs the consumer to stall while several quadwords are assembled. The stimulus reaches it by assembling quadwords from overlapping, out-of-order, clipped and zero-length pieces while never reading, until four entries are stored, then completing one more and probing the write ready. A flush is placed between two halves of a quadword so that only a cleared mask explains why no entry appears.

// File: rtl/qg_pkg.sv
package qg_pkg;
  localparam int LANES  = 16;
  localparam int LANE_W = 8;
  localparam int QW_W   = LANES * LANE_W;
  localparam int TAG_W  = 32;
  localparam int OFF_W  = $clog2(LANES);
  localparam int CNTW   = OFF_W + 1;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [QW_W-1:0]  data;
  } qg_entry_t;
endpackage

// File: rtl/qg_lane_merge.sv
module qg_lane_merge
  import qg_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  input  logic [CNTW-1:0]  cnt_i,
  input  logic [QW_W-1:0]  data_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [QW_W-1:0]  hold_i,
  output logic [LANES-1:0] mask_o,
  output logic [QW_W-1:0]  hold_o,
  output logic             full_o
);
  logic [QW_W-1:0] aligned;
  logic [CNTW-1:0] first;
  logic [CNTW-1:0] stop;

  assign aligned = data_i << (off_i * LANE_W);
  assign first   = {1'b0, off_i};
  assign stop    = first + cnt_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [CNTW-1:0] LANE_IDX = CNTW'(g);
    logic hit;
    assign hit = (LANE_IDX >= first) && (LANE_IDX < stop);
    assign mask_o[g] = mask_i[g] | hit;
    assign hold_o[g*LANE_W +: LANE_W] = hit ? aligned[g*LANE_W +: LANE_W]
                                            : hold_i[g*LANE_W +: LANE_W];
  end

  assign full_o = &mask_o;
endmodule

// File: rtl/qg_fifo.sv
module qg_fifo
  import qg_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  qg_entry_t        push_data_i,
  input  logic             pop_i,
  output qg_entry_t        head_o,
  output logic [LVL_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  qg_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic [LVL_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_i) wptr_d = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop_i)  rptr_d = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wptr_q] <= push_data_i;
  end

  assign head_o  = mem[rptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == LVL_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/qword_gather_fifo.sv
module qword_gather_fifo
  import qg_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [CNTW-1:0]  wr_cnt_i,
  input  logic [QW_W-1:0]  wr_data_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [QW_W-1:0]  rd_data_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [LVL_W-1:0] level_o
);
  logic [LANES-1:0] mask_q, mask_d;
  logic [QW_W-1:0]  hold_q, hold_d;
  logic             stage_v_q, stage_v_d;
  qg_entry_t        stage_q, stage_d;
  logic             hold_en, stage_en;

  logic [LANES-1:0] merge_mask;
  logic [QW_W-1:0]  merge_hold;
  logic             merge_full;
  logic             wr_fire, push, pop;
  logic             fifo_full, fifo_empty;
  qg_entry_t        head;

  qg_lane_merge u_merge (
    .off_i  (wr_off_i),
    .cnt_i  (wr_cnt_i),
    .data_i (wr_data_i),
    .mask_i (mask_q),
    .hold_i (hold_q),
    .mask_o (merge_mask),
    .hold_o (merge_hold),
    .full_o (merge_full)
  );

  assign wr_ready_o = ~stage_v_q | ~fifo_full;
  assign wr_fire    = wr_valid_i & wr_ready_o;
  assign push       = stage_v_q & ~fifo_full;
  assign pop        = rd_valid_o & rd_ready_i;

  always_comb begin
    mask_d    = mask_q;
    hold_d    = hold_q;
    stage_v_d = stage_v_q;
    stage_d   = stage_q;
    hold_en   = 1'b0;
    stage_en  = 1'b0;
    if (push) stage_v_d = 1'b0;
    if (wr_fire) begin
      if (merge_full) begin
        mask_d       = '0;
        stage_v_d    = 1'b1;
        stage_d.data = merge_hold;
        stage_d.tag  = wr_tag_i;
        stage_en     = 1'b1;
      end else begin
        mask_d  = merge_mask;
        hold_d  = merge_hold;
        hold_en = 1'b1;
      end
    end
    if (flush_i) mask_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      stage_v_q <= 1'b0;
    end else begin
      mask_q    <= mask_d;
      stage_v_q <= stage_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en)  hold_q  <= hold_d;
    if (stage_en) stage_q <= stage_d;
  end

  qg_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_data_i (stage_q),
    .pop_i       (pop),
    .head_o      (head),
    .count_o     (level_o),
    .full_o      (fifo_full),
    .empty_o     (fifo_empty)
  );

  assign rd_valid_o = ~fifo_empty;
  assign rd_data_o  = head.data;
  assign rd_tag_o   = head.tag;
endmodule

// File: rtl/qg_checker.sv
module qg_checker
  import qg_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_i,
  input logic             wr_ready_o,
  input logic             rd_valid_o,
  input logic             rd_ready_i,
  input logic [QW_W-1:0]  rd_data_o,
  input logic [TAG_W-1:0] rd_tag_o,
  input logic [LVL_W-1:0] level_o,
  input logic             stage_v,
  input logic [LANES-1:0] mask
);
  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LVL_W'(DEPTH)); // R7
  AST_VALID_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o == (level_o != '0)); // R7
  AST_POP_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && rd_ready_i) |=> (level_o <= $past(level_o))); // R7
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> ($stable(rd_data_o) && $stable(rd_tag_o))); // R7
  AST_NO_EARLY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_v |=> (level_o <= $past(level_o))); // R2
  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready_o |-> (level_o == LVL_W'(DEPTH))); // R8
  AST_FLUSH_EMPTIES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (mask == '0)); // R9
endmodule

bind qword_gather_fifo qg_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush_i    (flush_i),
  .wr_ready_o (wr_ready_o),
  .rd_valid_o (rd_valid_o),
  .rd_ready_i (rd_ready_i),
  .rd_data_o  (rd_data_o),
  .rd_tag_o   (rd_tag_o),
  .level_o    (level_o),
  .stage_v    (stage_v_q),
  .mask       (mask_q)
);

// File: tb/sim_qword_gather_fifo.sv
module sim_qword_gather_fifo;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush_i = 1'b0;
  logic         wr_valid_i = 1'b0;
  logic         wr_ready_o;
  logic [3:0]   wr_off_i = '0;
  logic [4:0]   wr_cnt_i = '0;
  logic [127:0] wr_data_i = '0;
  logic [31:0]  wr_tag_i = '0;
  logic         rd_valid_o;
  logic         rd_ready_i = 1'b0;
  logic [127:0] rd_data_o;
  logic [31:0]  rd_tag_o;
  logic [2:0]   level_o;

  qword_gather_fifo #(.DEPTH(4)) u0 (.*);

  always #5 clk = ~clk;

  int errs = 0, checks = 0, wnum = 0, exp_n = 0, rdi = 0;
  bit done = 1'b0;
  logic [7:0]   model_q [16];
  logic [15:0]  model_m = '0;
  logic [127:0] exp_d [8];
  logic [31:0]  exp_t [8];

  // {offset[3:0], count[4:0], expected level[2:0]}
  localparam logic [11:0] VEC [10] = '{
    {4'd0,  5'd4,  3'd0}, {4'd8,  5'd4,  3'd0}, {4'd2,  5'd2,  3'd0},
    {4'd4,  5'd4,  3'd0}, {4'd12, 5'd0,  3'd0}, {4'd12, 5'd8,  3'd1},
    {4'd15, 5'd1,  3'd1}, {4'd0,  5'd15, 3'd2}, {4'd0,  5'd16, 3'd3},
    {4'd10, 5'd3,  3'd3}};

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] off, input logic [4:0] cnt);
    logic [127:0] d = '0;
    bit acc = 1'b0;
    for (int k = 0; k < 16; k++) d[k*8 +: 8] = 8'(wnum * 19 + k + 1);
    while (!acc) begin
      @(negedge clk);
      wr_off_i = off; wr_cnt_i = cnt; wr_data_i = d;
      wr_tag_i = 32'hA000_0000 + 32'(wnum); wr_valid_i = 1'b1;
      acc = wr_ready_o;
      @(posedge clk);
      #1 wr_valid_i = 1'b0;
    end
    for (int k = 0; k < 16; k++) begin
      if (k < int'(cnt) && int'(off) + k < 16) begin
        model_q[int'(off) + k] = d[k*8 +: 8];
        model_m[int'(off) + k] = 1'b1;
      end
    end
    if (&model_m) begin
      for (int l = 0; l < 16; l++) exp_d[exp_n][l*8 +: 8] = model_q[l];
      exp_t[exp_n] = 32'hA000_0000 + 32'(wnum);
      exp_n++;
      model_m = '0;
    end
    wnum++;
  endtask

  task automatic do_flush();
    @(negedge clk); flush_i = 1'b1;
    @(posedge clk); #1 flush_i = 1'b0;
    model_m = '0;
  endtask

  task automatic pop_chk();
    @(negedge clk);
    while (!rd_valid_o) @(negedge clk);
    chk(rd_data_o == exp_d[rdi], "R3 R4 R5 R7 data", rd_data_o, exp_d[rdi]);
    chk(rd_tag_o == exp_t[rdi], "R6 tag", 128'(rd_tag_o), 128'(exp_t[rdi]));
    rd_ready_i = 1'b1;
    @(posedge clk); #1 rd_ready_i = 1'b0;
    rdi++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rd_valid_o == 1'b0, "R1 rd_valid", 128'(rd_valid_o), 0);
    chk(level_o == 3'd0, "R1 level", 128'(level_o), 0);
    chk(wr_ready_o == 1'b1, "R1 wr_ready", 128'(wr_ready_o), 1);

    // table walk: partial, overlap, zero count, clipping, any order
    for (int i = 0; i < 10; i++) begin
      put(VEC[i][11:8], VEC[i][7:3]);
      @(negedge clk);
      if (i == 5) chk(level_o == 3'd0, "R10 not yet pushed", 128'(level_o), 0);
      @(negedge clk);
      chk(level_o == VEC[i][2:0], "R2 R4 R10 level after write",
          128'(level_o), 128'(VEC[i][2:0]));
    end

    // flush between halves of a quadword
    do_flush();
    put(4'd0, 5'd10);
    put(4'd13, 5'd3);
    repeat (2) @(negedge clk);
    chk(level_o == 3'd3, "R9 no push after flush", 128'(level_o), 3);
    put(4'd10, 5'd3);
    repeat (2) @(negedge clk);
    chk(level_o == 3'd4, "R4 R9 completes after rewrite", 128'(level_o), 4);

    // fill staging slot while FIFO is full
    put(4'd0, 5'd16);
    repeat (2) @(negedge clk);
    chk(level_o == 3'd4, "R8 level stays full", 128'(level_o), 4);
    chk(wr_ready_o == 1'b0, "R8 write stalled", 128'(wr_ready_o), 0);

    for (int n = 0; n < 5; n++) pop_chk();
    repeat (2) @(negedge clk);
    chk(level_o == 3'd0, "R7 drained level", 128'(level_o), 0);
    chk(rd_valid_o == 1'b0, "R7 drained valid", 128'(rd_valid_o), 0);
    chk(wr_ready_o == 1'b1, "R8 ready back", 128'(wr_ready_o), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule